// File: doc/BRIEF.md
# Bus turnaround controller

This block sits between a processor core and the pad ring of a chip. It decides which of two drivers may push data onto a shared bidirectional data line: the core's own output driver, or the pad buffer that brings external data inward. The core signals with an active-low request when it wants to drive the bus. The controller hands the bus over with break-before-make in both directions. It first turns the current driver off. It then keeps both drivers off for a programmable number of whole clock cycles. Only after that does it enable the other driver. This prevents bus clash during turnaround.

An external memory controller can take the bus away at any moment through an asynchronous block input. Both drive enables drop at once, with no clock edge needed. They stay off while the block is held. After the block is released and synchronized to the clock, drive comes back only through a fresh dead-time gap. The direction after that gap follows the core's request at that time. The core's own test and bus-enable inputs are assumed tied inactive, so this controller alone gates the core drive.

Top module: `bus_turnaround`

## Requirements
- R1: While reset is asserted and the block input is low, the pad drive enable is 1 and the core drive enable is 0. Both stay that way after reset is released, as long as the core request stays high.
- R2: With the pad enabled, a low core request sampled at a clock edge turns the pad enable off after that edge. The core enable turns on after exactly DEAD_CYCLES further edges.
- R3: With the core enabled, a high core request sampled at a clock edge turns the core enable off after that edge. The pad enable turns on after exactly DEAD_CYCLES further edges.
- R4: The core drive enable and the pad drive enable are never 1 at the same time.
- R5: Before either enable rises, both enables have been 0 for at least DEAD_CYCLES consecutive clock cycles.
- R6: A high level on the asynchronous block input forces both enables to 0 at once, without waiting for a clock edge.
- R7: Both enables stay 0 while the block input is high. After it falls, they stay 0 for SYNC_STAGES edges plus one more edge, then for a DEAD_CYCLES gap. The chosen driver is enabled SYNC_STAGES+1+DEAD_CYCLES edges after the release.
- R8: At the end of every gap, the direction follows the core request sampled at the final gap edge. A low request selects the core, and a high request selects the pad. This holds even if the request changed during the gap.
- R9: The core request is a level. Holding it low keeps the core enabled, and holding it high keeps the pad enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sequencing uses rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_want_n | input | 1 | Active-low request from the core to drive the shared bus |
| arb_block | input | 1 | Asynchronous active-high bus take-away from the memory controller |
| core_drive_en | output | 1 | Enables the core's output driver onto the bus |
| pad_drive_en | output | 1 | Enables the pad buffer driving external data inward |

## Verification
A change of the core request shows up on the enable being released at the first rising edge that samples it. The enable being granted follows exactly DEAD_CYCLES edges later. A release of the block input takes SYNC_STAGES+1+DEAD_CYCLES edges to re-enable a driver, while asserting it drops both enables within a nanosecond and with no edge. Inputs are driven on falling edges. A cycle-level reference model, updated on rising edges from the inputs alone, predicts both enables, and the outputs are compared against it at the next falling edge. Directed runs also count edges explicitly for each of these latencies, and check the asynchronous drop one nanosecond after the block input rises.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    ST_PAD  = 2'd0,
    ST_GAP  = 2'd1,
    ST_CORE = 2'd2,
    ST_HOLD = 2'd3
  } dir_state_e;
endpackage

// File: rtl/bt_block_sync.sv
// Asynchronous-assert, synchronous-release stretcher for the bus take-away.
module bt_block_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_in,
  output logic blk_hold
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      logic q;
      if (g == 0) begin : g_first
        assign d = 1'b0;
      end else begin : g_next
        assign d = chain[g-1];
      end
      always_ff @(posedge clk or negedge rst_n or posedge blk_in) begin
        if (blk_in)      q <= 1'b1;
        else if (!rst_n) q <= 1'b0;
        else             q <= d;
      end
      assign chain[g] = q;
    end
  endgenerate

  assign blk_hold = chain[STAGES-1];
endmodule

// File: rtl/bt_gap_timer.sv
// Counts the dead-time cycles while the direction FSM sits in its gap state.
module bt_gap_timer #(
  parameter int DEAD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/bt_dir_fsm.sv
// Direction state machine: pad owns the bus, gap, core owns the bus, held off.
module bt_dir_fsm
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_n,
  input  logic       hold,
  input  logic       gap_done,
  output dir_state_e state
);
  dir_state_e nxt;

  always_comb begin
    nxt = state;
    if (hold) begin
      nxt = ST_HOLD;
    end else begin
      unique case (state)
        ST_PAD:  if (!want_n) nxt = ST_GAP;
        ST_CORE: if (want_n)  nxt = ST_GAP;
        ST_GAP:  if (gap_done) nxt = want_n ? ST_PAD : ST_CORE;
        ST_HOLD: nxt = ST_GAP;
        default: nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PAD;
    else        state <= nxt;
  end
endmodule

// File: rtl/bus_turnaround.sv
module bus_turnaround
  import bt_pkg::*;
#(
  parameter int DEAD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_want_n,
  input  logic arb_block,
  output logic core_drive_en,
  output logic pad_drive_en
);
  logic       blk_hold;
  logic       gap_done;
  dir_state_e state;

  bt_block_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_in   (arb_block),
    .blk_hold (blk_hold)
  );

  bt_gap_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_GAP),
    .done  (gap_done)
  );

  bt_dir_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_n   (core_want_n),
    .hold     (blk_hold),
    .gap_done (gap_done),
    .state    (state)
  );

  // The asynchronous hold gates both enables with no clock in the path.
  assign core_drive_en = (state == ST_CORE) && !blk_hold;
  assign pad_drive_en  = (state == ST_PAD)  && !blk_hold;
endmodule

// File: rtl/bus_turnaround_chk.sv
module bus_turnaround_chk #(
  parameter int DEAD_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic core_want_n,
  input logic arb_block,
  input logic core_drive_en,
  input logic pad_drive_en
);
  logic [15:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              off_run <= '0;
    else if (core_drive_en || pad_drive_en)  off_run <= '0;
    else if (off_run != 16'hFFFF)            off_run <= off_run + 1'b1;
  end

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_drive_en && pad_drive_en));

  p_core_dead_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_drive_en) |-> (32'(off_run) >= DEAD_CYCLES));

  p_pad_dead_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_drive_en) |-> (32'(off_run) >= DEAD_CYCLES));

  p_block_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_block |-> (!core_drive_en && !pad_drive_en));

  p_after_block_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arb_block) |-> (!core_drive_en && !pad_drive_en));

  p_pad_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drive_en && !core_want_n) |=> !pad_drive_en);

  p_core_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_drive_en && core_want_n) |=> !core_drive_en);
endmodule

bind bus_turnaround bus_turnaround_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_want_n   (core_want_n),
  .arb_block     (arb_block),
  .core_drive_en (core_drive_en),
  .pad_drive_en  (pad_drive_en)
);

// File: tb/bus_turnaround_test.sv
module bus_turnaround_test;
  localparam int DEAD = 2;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_want_n = 1'b1;
  logic arb_block = 1'b0;
  logic core_drive_en, pad_drive_en;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_turnaround #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .core_want_n(core_want_n), .arb_block(arb_block),
    .core_drive_en(core_drive_en), .pad_drive_en(pad_drive_en)
  );

  // Reference model, fed by the inputs only. Modes: 0 pad, 1 gap, 2 core, 3 held.
  int m_mode, m_cnt, m_rel;
  bit m_hold;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_rel = 0;
    end else begin
      m_hold = arb_block || (m_rel > 0);
      if (m_hold) m_mode = 3;
      else case (m_mode)
        0: if (!core_want_n) begin m_mode = 1; m_cnt = 0; end
        2: if (core_want_n)  begin m_mode = 1; m_cnt = 0; end
        1: if (m_cnt == DEAD - 1) m_mode = core_want_n ? 0 : 2;
           else m_cnt++;
        default: begin m_mode = 1; m_cnt = 0; end
      endcase
      if (arb_block) m_rel = SYNC;
      else if (m_rel > 0) m_rel--;
    end
  end

  function automatic bit exp_core(int mode, int rel, bit blk);
    return (mode == 2) && (rel == 0) && !blk;
  endfunction
  function automatic bit exp_pad(int mode, int rel, bit blk);
    return (mode == 0) && (rel == 0) && !blk;
  endfunction

  task automatic check(string req, bit ec, bit ep);
    checks++;
    if (core_drive_en !== ec || pad_drive_en !== ep) begin
      fails++;
      $display("FAIL %s: core=%0b pad=%0b expected core=%0b pad=%0b at %0t",
               req, core_drive_en, pad_drive_en, ec, ep, $time);
    end
  endtask

  task automatic check_model(string req);
    check(req, exp_core(m_mode, m_rel, arb_block), exp_pad(m_mode, m_rel, arb_block));
    checks++;
    if (core_drive_en && pad_drive_en) begin
      fails++;
      $display("FAIL R4: core=1 pad=1 expected not both at %0t", $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) step();
    check("R1 in reset", 1'b0, 1'b1);
    rst_n = 1'b1;
    // R9: request held high keeps the pad
    for (int i = 0; i < 4; i++) begin step(); check("R9 pad held", 1'b0, 1'b1); end
    check("R1 after reset", 1'b0, 1'b1);

    // R2: handover to core after exactly DEAD edges of gap
    core_want_n = 1'b0;
    for (int i = 1; i <= DEAD + 1; i++) begin
      step(); check("R2 to core", i == DEAD + 1, 1'b0);
    end
    for (int i = 0; i < 3; i++) begin step(); check("R9 core held", 1'b1, 1'b0); end

    // R3: handback to pad
    core_want_n = 1'b1;
    for (int i = 1; i <= DEAD + 1; i++) begin
      step(); check("R3 to pad", 1'b0, i == DEAD + 1);
    end

    // R8: request withdrawn during the gap returns to pad
    core_want_n = 1'b0;
    step(); check("R8 gap entry", 1'b0, 1'b0);
    core_want_n = 1'b1;
    for (int i = 2; i <= DEAD + 1; i++) begin
      step(); check("R8 follow request", 1'b0, i == DEAD + 1);
    end

    // R6/R7: take-away while core drives, then release
    core_want_n = 1'b0;
    repeat (DEAD + 2) step();
    check("R2 core before block", 1'b1, 1'b0);
    arb_block = 1'b1;
    #1 check("R6 async drop", 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin step(); check("R7 held off", 1'b0, 1'b0); end
    arb_block = 1'b0;
    for (int i = 1; i <= SYNC + 1 + DEAD; i++) begin
      step(); check("R7 release latency", i == SYNC + 1 + DEAD, 1'b0);
    end

    // Random phase checked against the model
    for (int n = 0; n < 3000; n++) begin
      step();
      check_model(m_mode == 3 ? "R7 random" : (core_want_n ? "R3 random" : "R2 random"));
      if ($urandom_range(5) == 0) core_want_n = ~core_want_n;
      if (arb_block) begin
        if ($urandom_range(2) == 0) arb_block = 1'b0;
      end else if ($urandom_range(39) == 0) begin
        arb_block = 1'b1;
        #1 check("R6 random async drop", 1'b0, 1'b0);
      end
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule